// File: doc/BRIEF.md
# Coarse Reciprocal Seed Generator

This unit produces a cheap reciprocal estimate for the range-reduction stage of a logarithm evaluator. An IEEE-754 single-precision operand is taken as a significand in [0.5, 1) times a power of two. The unit returns a positive float whose unbiased exponent is always zero, and whose value approximates the reciprocal of that significand. The power of two and the sign of the operand are dropped.

The estimate is chosen from a small table indexed by the four most significant stored fraction bits of the operand. Each result has at most five significant bits, counting the hidden one. A downstream multiplier can therefore scale the operand's significand by the seed at low cost and bring it close to 1.0. Zero, denormal, infinite and NaN operands all yield exactly 1.0. The result is registered, with one cycle of latency, and carries a matching valid flag.

Top module: `recip_seed_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so each result appears exactly one cycle after its operand.
- R2: For an operand whose exponent field is neither 0 nor 255, the result depends only on index k = `in_data[22:19]`. The exponent field, the sign bit and fraction bits 18..0 have no effect.
- R3: Every result has sign bit 31 equal to 0 and exponent field bits 30..23 equal to 127.
- R4: For a normal operand, result bits 22..19 equal q-16, where q = round(1024/(33+2k)). q is capped at 31 and never falls below 16. Result bits 18..0 are zero.
- R5: An operand with exponent field 0 (zero or denormal) or 255 (infinity or NaN) gives exactly 0x3F800000, whatever its sign and fraction.
- R6: For every normal operand, the product of the operand significand (0.5 + fraction/2^24) and the result value lies within 1/16 of 1.0.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R8: In a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_data | output | 32 | Single-precision reciprocal seed |

## Verification
All sixteen index values are driven with several exponents, both signs and different low fraction patterns. This separates a correct index choice from one that leaks exponent, sign or lower bits into the result. Zero, denormals of both extremes, infinities and NaNs are mixed in, to tell the special-operand path from the table path. Idle gaps between operands show whether the result holds or is overwritten. A bound on the significand-times-seed product confirms that the table entries actually reduce the argument toward 1.0.

// File: rtl/rseed_pkg.sv
package rseed_pkg;

  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_BIAS   = 127;

  localparam logic [FP_W-1:0] FP_ONE = 32'h3F80_0000;

  typedef struct packed {
    logic                 sign;
    logic [FP_EXP_W-1:0]  expo;
    logic [FP_FRAC_W-1:0] frac;
  } fp32_t;

  // Seed in units of 2^-(sig_w-1), for significand bucket k of width 2^-(iw+1)
  // inside [0.5, 1): round-to-nearest of 1 / bucket_centre, capped below 2.0.
  function automatic int seed_code(int iw, int sw, int k);
    longint num;
    longint den;
    longint q;
    num = longint'(1) << (sw + iw + 1);
    den = (longint'(1) << (iw + 1)) + 2 * longint'(k) + 1;
    q   = (2 * num + den) / (2 * den);
    if (q > (longint'(1) << sw) - 1) q = (longint'(1) << sw) - 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/rseed_classify.sv
module rseed_classify
  import rseed_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [FP_W-1:0]  op,
  output logic             is_special,
  output logic [IDX_W-1:0] index
);

  fp32_t f;
  logic  exp_zero;
  logic  exp_full;
  logic  unused_op_bits;

  assign f        = fp32_t'(op);
  assign exp_zero = (f.expo == '0);
  assign exp_full = (f.expo == '1);

  assign is_special = exp_zero | exp_full;
  assign index      = f.frac[FP_FRAC_W-1 -: IDX_W];

  assign unused_op_bits = ^{f.sign, f.frac[FP_FRAC_W-IDX_W-1:0]};

endmodule

// File: rtl/rseed_lookup.sv
module rseed_lookup
  import rseed_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SIG_W = 5
) (
  input  logic [IDX_W-1:0] index,
  output logic [SIG_W-2:0] code
);

  localparam int DEPTH = 1 << IDX_W;

  logic [SIG_W-2:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int QV = seed_code(IDX_W, SIG_W, g);
    assign table_q[g] = QV[SIG_W-2:0];
  end

  assign code = table_q[index];

endmodule

// File: rtl/rseed_pack.sv
module rseed_pack
  import rseed_pkg::*;
#(
  parameter int SIG_W = 5
) (
  input  logic             is_special,
  input  logic [SIG_W-2:0] code,
  output logic [FP_W-1:0]  word
);

  localparam int LOW_W = FP_FRAC_W - (SIG_W - 1);

  fp32_t packed_seed;

  always_comb begin
    packed_seed.sign = 1'b0;
    packed_seed.expo = FP_EXP_W'(FP_BIAS);
    packed_seed.frac = {code, {LOW_W{1'b0}}};
  end

  assign word = is_special ? FP_ONE : packed_seed;

endmodule

// File: rtl/recip_seed_unit.sv
module recip_seed_unit
  import rseed_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SIG_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);

  localparam int LOW_W = FP_FRAC_W - (SIG_W - 1);

  logic             op_special;
  logic [IDX_W-1:0] op_index;
  logic [SIG_W-2:0] seed_frac;
  logic [FP_W-1:0]  seed_word;

  rseed_classify #(.IDX_W(IDX_W)) u_classify (
    .op         (in_data),
    .is_special (op_special),
    .index      (op_index)
  );

  rseed_lookup #(.IDX_W(IDX_W), .SIG_W(SIG_W)) u_lookup (
    .index (op_index),
    .code  (seed_frac)
  );

  rseed_pack #(.SIG_W(SIG_W)) u_pack (
    .is_special (op_special),
    .code       (seed_frac),
    .word       (seed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= seed_word;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid lost");                    // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("spurious valid");             // R1
  AST_SIGN_EXP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[31] == 1'b0 && out_data[30:23] == 8'd127))
    else $error("sign or exponent wrong");                                // R3
  AST_LOW_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[LOW_W-1:0] == '0)) else $error("low bits set"); // R4
  AST_SPECIAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_special) |=> (out_data == FP_ONE))
    else $error("special not one");                                       // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)) else $error("data changed idle");    // R8

endmodule

// File: tb/tb_recip_seed_unit.sv
module tb_recip_seed_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic        m_valid = 1'b0;
  logic [31:0] m_data  = '0;
  logic [31:0] m_src   = '0;

  always #5 clk = ~clk;

  recip_seed_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] ref_seed(input logic [31:0] x);
    int  e;
    int  k;
    int  q;
    real c;
    e = int'(x[30:23]);
    k = int'(x[22:19]);
    if (e == 0 || e == 255) return 32'h3F80_0000;
    c = 0.5 + (2.0 * k + 1.0) / 64.0;
    q = $rtoi(16.0 / c + 0.5);
    if (q > 31) q = 31;
    if (q < 16) q = 16;
    return {1'b0, 8'd127, 4'(q - 16), 19'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one stage of delay, hold on idle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_data <= ref_seed(in_data);
        m_src  <= in_data;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == m_valid, "R1 valid", {31'd0, out_valid}, {31'd0, m_valid});
      if (m_valid) begin
        chk(out_data == m_data, "R2/R4/R5 value", out_data, m_data);
        chk(out_data[31:23] == 9'h07F && out_data[18:0] == 19'd0, "R3 fixed fields", out_data, m_data);
        if (m_src[30:23] != 8'd0 && m_src[30:23] != 8'hFF) begin
          real p;
          p = (0.5 + real'(m_src[22:0]) / 16777216.0) * (1.0 + real'(out_data[22:0]) / 8388608.0);
          chk(p >= 0.9375 && p <= 1.0625, "R6 product bound", out_data, m_data);
        end
      end else begin
        chk(out_data == m_data, "R8 hold", out_data, m_data);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_BEEF;
    end
  endtask

  task automatic probe(input logic [31:0] d, output logic [31:0] r);
    send(d);
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
  endtask

  initial begin
    logic [31:0] ra;
    logic [31:0] rb;
    logic [7:0]  exps [4];
    exps[0] = 8'd1; exps[1] = 8'd127; exps[2] = 8'd200; exps[3] = 8'd254;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_data == 32'd0, "R7 reset state", out_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 explicit table corners: k=0 -> q=31, k=15 -> q=16
    probe(32'h3F80_0000, ra);
    chk(ra == 32'h3FF8_0000, "R4 k=0 seed", ra, 32'h3FF8_0000);
    probe(32'h3FFF_FFFF, ra);
    chk(ra == 32'h3F80_0000, "R4 k=15 seed", ra, 32'h3F80_0000);

    // R2/R6 exponent, sign and low bits ignored
    probe(32'h4134_0000, ra);
    probe(32'hC0B7_ABCD, rb);
    chk(ra == rb, "R2 R6 exp/sign/low bits ignored", rb, ra);

    // Sweep of all indices
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 4; j++) begin
        send({1'(j & 1), exps[j], 4'(k), 19'(k * 40503 + j * 977)});
        if ((k + j) % 3 == 0) idle(1 + j);
      end
    end
    idle(2);

    // R5 special operands
    probe(32'h0000_0000, ra); chk(ra == 32'h3F80_0000, "R5 +zero", ra, 32'h3F80_0000);
    probe(32'h8000_0000, ra); chk(ra == 32'h3F80_0000, "R5 -zero", ra, 32'h3F80_0000);
    probe(32'h0000_0001, ra); chk(ra == 32'h3F80_0000, "R5 tiny denormal", ra, 32'h3F80_0000);
    probe(32'h807F_FFFF, ra); chk(ra == 32'h3F80_0000, "R5 big denormal", ra, 32'h3F80_0000);
    probe(32'h7F80_0000, ra); chk(ra == 32'h3F80_0000, "R5 +inf", ra, 32'h3F80_0000);
    probe(32'hFF80_0000, ra); chk(ra == 32'h3F80_0000, "R5 -inf", ra, 32'h3F80_0000);
    probe(32'h7FC0_1234, ra); chk(ra == 32'h3F80_0000, "R5 NaN", ra, 32'h3F80_0000);

    // R8 hold across a long idle after a non-one result
    probe(32'h3F90_0000, ra);
    idle(5);
    chk(out_data == ra, "R8 hold after idle", out_data, ra);

    // Back-to-back stream of mixed operands
    send(32'h0000_0000); send(32'h3FA0_0000); send(32'h7F80_0000); send(32'h4270_0000);
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule